// File: doc/BRIEF.md
# Three-Channel Framed PWM Generator

This block drives three pulse-width-modulated outputs that share one frame timebase. Each frame is cut into 64 equal slots. Every channel goes high at the start of a frame and stays high for a number of slots set by its own 6-bit duty code, then goes low for the rest of the frame. A 4-bit frame code selects the frame length as a multiple of the input clock, from 1536 cycles down to 256. Several frame codes are aliases of one another.

A separate clock pin can output the input clock divided by 2 or by 8, or stay low. An active-low inhibit input forces every output low at once. This keeps the pins quiet while the control codes still hold meaningless power-up values. The internal counters keep running during inhibit. Duty and frame codes are sampled only at a frame boundary, so a code written in the middle of a frame never cuts a pulse short.

Top module: `pwm_frame_gen`

## Requirements
- R1: For frame codes 0 to 10 (bit 0 of `frame_sel` is the least significant), a frame lasts 1536 − 128×code input clock cycles. Code 0 gives 1536 cycles and code 10 gives 256 cycles.
- R2: Frame code 11, and every code with both bits 3 and 2 set (12 to 15), gives an 896-cycle frame, the same as code 5.
- R3: A channel whose duty code is D (bit 0 is the least significant) is high for exactly (D+1)×L/64 cycles starting at the first cycle of a frame of length L, then low to the end of the frame. D = 63 keeps the channel high for the whole frame.
- R4: All three channels use one timebase. Each channel is high in the first cycle of every frame and falls at most once per frame, independently of the other channels.
- R5: Duty and frame codes are captured only in the cycle that starts a frame. Changing them during a frame has no effect on that frame.
- R6: While `inhibit_n` is low, `pwm_out` and `clk_out` are low in the same cycle. The frame and divider counters keep running.
- R7: With `clk_mode` = 2'b01, `clk_out` is bit 0 of a 3-bit cycle counter, giving the clock divided by 2. With 2'b10 it is bit 2, giving the clock divided by 8. Both are 50% duty. The counter is zero in reset and advances on every clock edge. Modes 2'b00 and 2'b11 hold `clk_out` low.
- R8: `rst_n` is an asynchronous active-low reset. While it is asserted all outputs are low. The first frame starts at the first rising clock edge after release and captures the codes present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_n | input | 1 | Low forces all outputs low |
| duty_a | input | 6 | Duty code, channel 0 |
| duty_b | input | 6 | Duty code, channel 1 |
| duty_c | input | 6 | Duty code, channel 2 |
| frame_sel | input | 4 | Frame length code |
| clk_mode | input | 2 | Clock pin mode: 01 divide by 2, 10 divide by 8, else low |
| pwm_out | output | 3 | PWM outputs, bit i is channel i |
| clk_out | output | 1 | Divided clock output |

## Verification
The bench walks all sixteen frame codes and compares each channel's high time with the expected value, frame by frame. A wrong entry in the code table, or an alias that is missing, would show up as a wrong high-time count. Duty codes 0 and 63 are driven directly: an off-by-one in the slot compare would give zero pulse width or a dip at the end of the frame. Codes are scrambled in the middle of every frame, so a design that captured them outside the frame boundary would bend the waveform in that frame. Inhibited frames and every clock mode are also covered, so a design that left a pin unmasked or picked the wrong divider bit would be caught.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
  localparam int CHANNELS = 3;
  localparam int SLOT_W   = 6;
  localparam int CODE_W   = 4;
  localparam int PRE_W    = 5;
  localparam int DIV_W    = 3;
  localparam int LAST_LINEAR_CODE = 10;
  localparam int BASE_SLOT_CYCLES = 24;
  localparam int STEP_SLOT_CYCLES = 2;
  localparam int ALIAS_SLOT_CYCLES = 14;

  typedef enum logic [1:0] {
    CLKM_OFF  = 2'b00,
    CLKM_DIV2 = 2'b01,
    CLKM_DIV8 = 2'b10,
    CLKM_OFF2 = 2'b11
  } clk_mode_e;

  // Cycles per slot (frame length / 64) for a frame code.
  function automatic logic [PRE_W-1:0] slot_cycles(input logic [CODE_W-1:0] code);
    int c;
    c = int'(code);
    if (c <= LAST_LINEAR_CODE)
      return PRE_W'(BASE_SLOT_CYCLES - STEP_SLOT_CYCLES * c);
    return PRE_W'(ALIAS_SLOT_CYCLES);
  endfunction
endpackage

// File: rtl/pwmf_timebase.sv
module pwmf_timebase
  import pwmf_pkg::*;
#(
  parameter int TB_SLOT_W = SLOT_W,
  parameter int TB_PRE_W  = PRE_W,
  parameter int TB_CODE_W = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TB_CODE_W-1:0] frame_sel_i,
  output logic [TB_SLOT_W-1:0] slot_o,
  output logic                 load_o,
  output logic                 run_o
);
  localparam logic [TB_SLOT_W-1:0] LAST_SLOT = '1;

  logic [TB_PRE_W-1:0]  presc_q, presc_d;
  logic [TB_PRE_W-1:0]  plen_q, plen_d;
  logic [TB_SLOT_W-1:0] slot_q, slot_d;
  logic                 run_q, run_d;
  logic                 slot_end, frame_end, load;

  always_comb begin
    slot_end  = (presc_q == (plen_q - TB_PRE_W'(1)));
    frame_end = run_q && slot_end && (slot_q == LAST_SLOT);
    load      = !run_q || frame_end;

    presc_d = presc_q;
    slot_d  = slot_q;
    plen_d  = plen_q;
    run_d   = run_q;
    if (load) begin
      presc_d = '0;
      slot_d  = '0;
      plen_d  = TB_PRE_W'(slot_cycles(frame_sel_i));
      run_d   = 1'b1;
    end else if (slot_end) begin
      presc_d = '0;
      slot_d  = slot_q + TB_SLOT_W'(1);
    end else begin
      presc_d = presc_q + TB_PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      slot_q  <= '0;
      plen_q  <= '0;
      run_q   <= 1'b0;
    end else begin
      presc_q <= presc_d;
      slot_q  <= slot_d;
      plen_q  <= plen_d;
      run_q   <= run_d;
    end
  end

  assign slot_o = slot_q;
  assign load_o = load;
  assign run_o  = run_q;
endmodule

// File: rtl/pwmf_channel.sv
module pwmf_channel
  import pwmf_pkg::*;
#(
  parameter int CH_SLOT_W = SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 run_i,
  input  logic [CH_SLOT_W-1:0] slot_i,
  input  logic [CH_SLOT_W-1:0] duty_i,
  output logic                 pwm_o
);
  logic [CH_SLOT_W-1:0] duty_q, duty_d;

  always_comb begin
    duty_d = duty_q;
    if (load_i) duty_d = duty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  assign pwm_o = run_i && (slot_i <= duty_q);
endmodule

// File: rtl/pwmf_clkdiv.sv
module pwmf_clkdiv
  import pwmf_pkg::*;
#(
  parameter int CD_DIV_W = DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output logic       clk_o
);
  logic [CD_DIV_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CD_DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    case (clk_mode_e'(mode_i))
      CLKM_DIV2: clk_o = cnt_q[0];
      CLKM_DIV8: clk_o = cnt_q[CD_DIV_W-1];
      default:   clk_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_frame_gen.sv
module pwm_frame_gen
  import pwmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit_n,
  input  logic [SLOT_W-1:0] duty_a,
  input  logic [SLOT_W-1:0] duty_b,
  input  logic [SLOT_W-1:0] duty_c,
  input  logic [CODE_W-1:0] frame_sel,
  input  logic [1:0]        clk_mode,
  output logic [CHANNELS-1:0] pwm_out,
  output logic              clk_out
);
  logic [SLOT_W-1:0]   frame_slot;
  logic                frame_load;
  logic                frame_run;
  logic [CHANNELS-1:0] chan_raw;
  logic                div_clk;
  logic [SLOT_W-1:0]   duty_arr [CHANNELS];

  assign duty_arr[0] = duty_a;
  assign duty_arr[1] = duty_b;
  assign duty_arr[2] = duty_c;

  pwmf_timebase #(.TB_SLOT_W(SLOT_W), .TB_PRE_W(PRE_W), .TB_CODE_W(CODE_W)) u_timebase (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sel_i (frame_sel),
    .slot_o      (frame_slot),
    .load_o      (frame_load),
    .run_o       (frame_run)
  );

  for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_chan
    pwmf_channel #(.CH_SLOT_W(SLOT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (frame_load),
      .run_i  (frame_run),
      .slot_i (frame_slot),
      .duty_i (duty_arr[gi]),
      .pwm_o  (chan_raw[gi])
    );
  end

  pwmf_clkdiv #(.CD_DIV_W(DIV_W)) u_clkdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (clk_mode),
    .clk_o  (div_clk)
  );

  assign pwm_out = chan_raw & {CHANNELS{inhibit_n}};
  assign clk_out = div_clk & inhibit_n;
endmodule

// File: rtl/pwmf_checker.sv
module pwmf_checker
  import pwmf_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                inhibit_n,
  input logic [1:0]          clk_mode,
  input logic [CHANNELS-1:0] pwm_out,
  input logic                clk_out,
  input logic                frame_load,
  input logic                frame_run,
  input logic [SLOT_W-1:0]   frame_slot,
  input logic [CHANNELS-1:0] chan_raw
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  p_inhibit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (pwm_out == '0) && !clk_out);

  p_all_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (chan_raw == '1));

  p_wrap_at_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && frame_run) |-> (frame_slot == LAST_SLOT));

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_run && !frame_load) |=>
      ((frame_slot == $past(frame_slot)) || (frame_slot == $past(frame_slot) + SLOT_W'(1))));

  p_div2_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && clk_mode == 2'b01 && $past(clk_mode) == 2'b01 &&
     inhibit_n && $past(inhibit_n)) |-> (clk_out != $past(clk_out)));

  for (genvar gi = 0; gi < CHANNELS; gi++) begin : g_fall
    p_single_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_load && !chan_raw[gi]) |=> !chan_raw[gi]);
  end
endmodule

bind pwm_frame_gen pwmf_checker u_pwmf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .inhibit_n  (inhibit_n),
  .clk_mode   (clk_mode),
  .pwm_out    (pwm_out),
  .clk_out    (clk_out),
  .frame_load (frame_load),
  .frame_run  (frame_run),
  .frame_slot (frame_slot),
  .chan_raw   (chan_raw)
);

// File: tb/test_pwm_frame_gen.sv
`timescale 1ns/1ps
module test_pwm_frame_gen;
  logic       clk;
  logic       rst_n;
  logic       inhibit_n;
  logic [5:0] duty_a, duty_b, duty_c;
  logic [3:0] frame_sel;
  logic [1:0] clk_mode;
  logic [2:0] pwm_out;
  logic       clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  localparam int NUM_FRAMES = 40;

  pwm_frame_gen i_pwm_frame_gen (
    .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n),
    .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .frame_sel(frame_sel), .clk_mode(clk_mode),
    .pwm_out(pwm_out), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int frame_len(input int code);
    if (code <= 10) return 1536 - 128 * code;
    return 896;
  endfunction

  function automatic int high_len(input int duty, input int code);
    return (duty + 1) * frame_len(code) / 64;
  endfunction

  function automatic bit clk_expect(input int mode, input int gcyc);
    int cnt;
    cnt = (gcyc + 1) % 8;
    if (mode == 1) return cnt[0];
    if (mode == 2) return cnt[2];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pick_next(input int f);
    if (f < 16) frame_sel = 4'(f);
    else        frame_sel = 4'($urandom_range(0, 15));
    case (f)
      0: begin duty_a = 6'd0;  duty_b = 6'd63; duty_c = 6'd7;  end
      1: begin duty_a = 6'd55; duty_b = 6'd31; duty_c = 6'd1;  end
      2: begin duty_a = 6'd63; duty_b = 6'd0;  duty_c = 6'd62; end
      default: begin
        duty_a = 6'($urandom_range(0, 63));
        duty_b = 6'($urandom_range(0, 63));
        duty_c = 6'($urandom_range(0, 63));
      end
    endcase
    clk_mode  = 2'($urandom_range(0, 3));
    inhibit_n = !(f == 20 || f == 21 || f == 33);
  endtask

  task automatic disturb();
    duty_a    = ~duty_a;
    duty_b    = duty_b + 6'd17;
    duty_c    = ~duty_c;
    frame_sel = frame_sel + 4'd7;
  endtask

  initial begin
    int gcyc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    inhibit_n = 1'b1;
    duty_a = 6'd63; duty_b = 6'd63; duty_c = 6'd63;
    frame_sel = 4'd10;
    clk_mode = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs low while reset held, even with inhibit released and mode active
    check(pwm_out == 3'b000, "R8 reset pwm_out", int'(pwm_out), 0);
    check(clk_out == 1'b0,   "R8 reset clk_out", int'(clk_out), 0);
    pick_next(0);
    rst_n = 1'b1;
    @(posedge clk);
    gcyc = 0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      int l_duty[3];
      int l_code, l_mode, flen;
      bit l_inh;
      int hi_cnt[3];
      int shape_bad[3];
      int clk_bad;
      string tag;
      l_duty[0] = int'(duty_a); l_duty[1] = int'(duty_b); l_duty[2] = int'(duty_c);
      l_code = int'(frame_sel);
      l_mode = int'(clk_mode);
      l_inh  = inhibit_n;
      flen   = frame_len(l_code);
      clk_bad = 0;
      for (int c = 0; c < 3; c++) begin hi_cnt[c] = 0; shape_bad[c] = 0; end
      for (int t = 0; t < flen; t++) begin
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
          bit exp_b;
          exp_b = l_inh && (t < high_len(l_duty[c], l_code));
          if (pwm_out[c] != exp_b) shape_bad[c]++;
          if (pwm_out[c]) hi_cnt[c]++;
        end
        if (clk_out != (l_inh && clk_expect(l_mode, gcyc))) clk_bad++;
        gcyc++;
        if (t == flen / 2) disturb();
        if (t == flen - 1) pick_next(f + 1);
        @(posedge clk);
      end
      tag = (l_code > 10) ? "R2 aliased code" : "R1 linear code";
      for (int c = 0; c < 3; c++) begin
        int exp_hi;
        exp_hi = l_inh ? high_len(l_duty[c], l_code) : 0;
        if (l_inh)
          check(hi_cnt[c] == exp_hi,
                $sformatf("%s R3 high time f%0d ch%0d code%0d duty%0d", tag, f, c, l_code, l_duty[c]),
                hi_cnt[c], exp_hi);
        else
          check(hi_cnt[c] == 0, $sformatf("R6 inhibited high time f%0d ch%0d", f, c), hi_cnt[c], 0);
        check(shape_bad[c] == 0,
              $sformatf("R4 R5 waveform shape f%0d ch%0d bad cycles", f, c), shape_bad[c], 0);
      end
      check(clk_bad == 0, $sformatf("R7 clk_out mode%0d f%0d bad cycles", l_mode, f), clk_bad, 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule